// File: doc/BRIEF.md
# Latched Address One-Hot Decoder

This block turns a 4-bit binary code into sixteen active-high select lines. At most one of those lines is high at a time. A holding stage sits in front of the decoder. While the latch-enable input is high, the stage tracks the live address and the decoder follows it directly. While latch enable is low, the stage keeps the last captured code, so later activity on the address pins has no effect on the outputs.

A separate active-low output enable blanks all sixteen lines and leaves the stored code untouched. Tying the address to a destination and driving the output enable with serial data turns the block into a 1-to-16 demultiplexer: the chosen line carries the inverse of the enable level.

Inside a clocked chip, the holding stage is a register. On every rising clock edge at which latch enable is high, it loads the address. The decoder input is selected by a two-phase mode derived from latch enable. In phase TRACK (latch enable high), the decoder takes the live address, so the output follows it within the same cycle. In phase HOLD (latch enable low), the decoder takes the stored code. The phase changes from HOLD to TRACK when latch enable rises and from TRACK to HOLD when it falls. An active-low asynchronous reset clears the stored code to 0.

Top module: `latched_onehot_dec`

## Requirements
- R1: While rst_n is low, and after it is released, the stored code is 0. With le low and en_n low, sel is therefore 16'h0001.
- R2: While le is high, sel equals a one-hot pattern with bit number addr set, where addr is binary with bit 0 least significant. This holds in the same cycle that addr is applied.
- R3: On each rising clk edge with le high and rst_n high, the stored code takes the value of addr.
- R4: While le is low, changes on addr neither change the stored code nor change sel.
- R5: While en_n is high, all sixteen bits of sel are 0.
- R6: Toggling en_n never changes the stored code. After any toggling, driving en_n low selects the line of the code stored before the toggling.
- R7: At most one bit of sel is high in every cycle, and exactly one bit is high whenever en_n is low.
- R8: With le low, sel[k] equals the inverse of en_n, where k is the stored code, and every other bit of sel is 0. This is the demultiplexer mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the holding register |
| rst_n | input | 1 | Asynchronous active-low reset; clears the stored code |
| addr_i | input | 4 | Binary address, bit 0 least significant |
| le_i | input | 1 | Latch enable: high = track the address, low = hold |
| en_n_i | input | 1 | Active-low output enable, or the data input in demultiplexer use |
| sel_o | output | 16 | One-hot active-high select lines |

## Verification
The assertions check, on every clock, the properties that hold at all times:
- the outputs are one-hot or zero;
- the outputs are zero while en_n is high;
- exactly one output is high while en_n is low;
- the stored code loads on edges with le high and holds on edges with le low;
- toggling the enable never disturbs the stored code.

Only the bench scenarios can show the mapping from each address value to its own output line. The same holds for the value surviving a blanked interval and for the reset value. The bench shows these by sweeping every address under every combination of le and en_n, and by comparing against a behavioural model.

// File: rtl/latched_onehot_dec_pkg.sv
package latched_onehot_dec_pkg;
    typedef enum logic {
        PH_HOLD  = 1'b0,
        PH_TRACK = 1'b1
    } phase_e;
endpackage

// File: rtl/lod_code_hold.sv
module lod_code_hold #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] code_in,
    output logic [ADDR_W-1:0] code_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
        end else if (load) begin
            code_q <= code_in;
        end
    end

    p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (code_q == $past(code_in)));
    p_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(code_q));
endmodule

// File: rtl/lod_onehot.sv
module lod_onehot #(
    parameter int ADDR_W = 4,
    localparam int OUT_N = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] code,
    output logic [OUT_N-1:0]  hot
);
    for (genvar g = 0; g < OUT_N; g++) begin : g_line
        assign hot[g] = (code == ADDR_W'(g));
    end
endmodule

// File: rtl/lod_gate.sv
module lod_gate #(
    parameter int WIDTH = 16
) (
    input  logic             en_n,
    input  logic [WIDTH-1:0] hot,
    output logic [WIDTH-1:0] sel
);
    always_comb begin
        sel = en_n ? '0 : hot;
    end
endmodule

// File: rtl/latched_onehot_dec.sv
module latched_onehot_dec
    import latched_onehot_dec_pkg::*;
#(
    parameter int ADDR_W = 4,
    localparam int OUT_N = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              le_i,
    input  logic              en_n_i,
    output logic [OUT_N-1:0]  sel_o
);
    phase_e            phase;
    logic [ADDR_W-1:0] held_code;
    logic [ADDR_W-1:0] dec_code;
    logic [OUT_N-1:0]  hot;

    always_comb begin
        phase = le_i ? PH_TRACK : PH_HOLD;
    end

    lod_code_hold #(.ADDR_W(ADDR_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (phase == PH_TRACK),
        .code_in (addr_i),
        .code_q  (held_code)
    );

    always_comb begin
        unique case (phase)
            PH_TRACK: dec_code = addr_i;
            PH_HOLD:  dec_code = held_code;
        endcase
    end

    lod_onehot #(.ADDR_W(ADDR_W)) u_dec (
        .code (dec_code),
        .hot  (hot)
    );

    lod_gate #(.WIDTH(OUT_N)) u_gate (
        .en_n (en_n_i),
        .hot  (hot),
        .sel  (sel_o)
    );

    p_mutex_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_o));
    p_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en_n_i |-> ($countones(sel_o) == 1));
    p_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
        en_n_i |-> (sel_o == '0));
    p_en_indep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!le_i && !$stable(en_n_i)) |=> $stable(held_code));
    p_demux_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !le_i |-> (sel_o[held_code] == !en_n_i));
endmodule

// File: tb/latched_onehot_dec_tb.sv
module latched_onehot_dec_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr_i = '0;
    logic        le_i = 1'b0;
    logic        en_n_i = 1'b1;
    logic [15:0] sel_o;

    int n_vec = 0;
    int n_bad = 0;
    int model_code = 0;

    always #5 clk = ~clk;

    latched_onehot_dec u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr_i (addr_i),
        .le_i   (le_i),
        .en_n_i (en_n_i),
        .sel_o  (sel_o)
    );

    function automatic logic [15:0] expect_sel(int a, bit le, bit en_n);
        int code;
        code = le ? a : model_code;
        if (en_n) return 16'h0000;
        return 16'h0001 << code;
    endfunction

    task automatic check(string req, logic [15:0] exp);
        n_vec++;
        if (sel_o !== exp) begin
            n_bad++;
            $display("FAIL %s: sel=%h expected %h", req, sel_o, exp);
        end
    endtask

    // Drive at negedge, compare mid-low-phase, then step the model at posedge.
    task automatic apply(string req, int a, bit le, bit en_n);
        @(negedge clk);
        addr_i = 4'(a);
        le_i = le;
        en_n_i = en_n;
        #1;
        check(req, expect_sel(a, le, en_n));
        if ($countones(sel_o) > 1) begin
            n_bad++;
            $display("FAIL R7: sel=%h has %0d bits, expected <=1", sel_o, $countones(sel_o));
        end
        @(posedge clk);
        if (le) model_code = a;
    endtask

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog: sel=%h expected completion", sel_o);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (2) @(posedge clk);
        @(negedge clk);
        le_i = 0;
        en_n_i = 0;
        addr_i = 4'd9;
        #1;
        check("R1 in reset", 16'h0001);
        rst_n = 1;
        model_code = 0;
        apply("R1 after reset", 7, 0, 0);

        // R2 / R3: transparency and capture
        for (int a = 0; a < 16; a++) apply("R2 track", a, 1, 0);
        apply("R3 capture 11", 11, 1, 0);
        apply("R3 hold 11", 3, 0, 0);

        // R4: address changes while holding are ignored
        for (int a = 0; a < 16; a++) apply("R4 frozen", a, 0, 0);

        // R5 / R6: blanking, enable toggles keep the code
        for (int i = 0; i < 6; i++) apply("R5 blank", i * 3, 0, i % 2);
        apply("R6 code kept", 0, 0, 0);
        apply("R5 blank track", 6, 1, 1);
        apply("R6 loaded while blank", 2, 0, 0);

        // R8: demultiplexer mode, serial data on en_n
        apply("R3 set dest", 13, 1, 1);
        for (int i = 0; i < 8; i++) apply("R8 demux", 4, 0, (8'hA6 >> i) & 1);

        // Full sweep under every le / en_n combination (R7)
        for (int a = 0; a < 16; a++)
            for (int m = 0; m < 4; m++)
                apply("R7 sweep", a, m[1], m[0]);

        // R1: mid-run reset clears the stored code
        apply("R3 set 9", 9, 1, 0);
        @(negedge clk);
        le_i = 0;
        rst_n = 0;
        #1;
        model_code = 0;
        check("R1 mid reset", 16'h0001);
        @(negedge clk);
        rst_n = 1;
        apply("R1 after mid reset", 5, 0, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule